// File: doc/BRIEF.md
# Byte-Strobe Register File with Field-Boundary Checking

This block is a small memory-mapped register file. A requester presents a request made of valid, address, write flag, write data and a 4-bit byte-lane strobe. The block answers in the same cycle with read data, an error flag and a ready signal that is always high. Four word offsets are decoded. One of them holds two independent registers packed into consecutive byte lanes: an 8-bit register in lane 0 and a 16-bit register in lanes 1 and 2.

Writes may use any strobe pattern, with one limit: no field may be written in part. The block marks each place where the strobe changes from set to clear between two neighbouring lanes. If such a change falls inside a field that spans both lanes, the write is rejected with an error and every field keeps its value. A field that passes this check is rewritten as a whole whenever any of its lanes is strobed. Reads return the OR of all registers that match the address, so both packed registers appear together in one word.

Top module: `strobe_regfile`

## Requirements
- R1: The block decodes exactly four offsets: CTRL at 0x00, PACK at 0x04, FULL at 0x08 and SPLIT at 0x0C, compared on all address bits. A valid request to any other address returns error=1 and read data 0, and changes no field.
- R2: A valid request to a decoded offset returns that offset's word: CTRL = {c_top[31:24], c_mid[23:16], c_low[15:0]}, PACK = {8'h00, p_half[23:8], p_byte[7:0]}, FULL = f_word[31:0], SPLIT = {s_hi[31:16], 8'h00, s_lo[7:0]}. When valid is low, read data is 0.
- R3: A field is written only when at least one strobe bit of its lanes is set (strobe bit n covers data bits 8n+7:8n). A field with no strobed lane keeps its value, and with valid low no field changes.
- R4: For each lane pair (n, n+1), n = 0..2, an edge exists when strobe[n] differs from strobe[n+1]. A write to a decoded offset whose edge lies inside a field spanning both lanes returns error=1. For example, FULL accepts only strobes 0000 and 1111, and strobe 0100 at SPLIT is rejected.
- R5: A write that returns error=1 leaves every field of every register unchanged.
- R6: At PACK both registers decode together. Strobe 0001 writes only p_byte, 0110 writes only p_half, 0111 writes both, and 1000 writes neither without error. Strobes 0010 and 0100 are rejected.
- R7: ready is 1 at all times after reset. Read data and error belong to the same cycle as the request, and a write becomes visible on the cycle after its clock edge.
- R8: After the active-low asynchronous reset, CTRL reads 0xA55A0F0F, PACK reads 0x00123456, FULL reads 0xDEADBEEF and SPLIT reads 0xCAFE0042.
- R9: A write with strobe 0000 to a decoded offset returns error=0 and changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| req_strb_i | input | 4 | Byte-lane strobe, bit n covers bits 8n+7:8n |
| rsp_rdata_o | output | 32 | Read data |
| rsp_error_o | output | 1 | Miss or rejected write |
| rsp_ready_o | output | 1 | Request accepted, always high |

## Verification
The bench uses the default parameters: an 8-bit address, offsets 0x00 to 0x0C, and distinct reset words. With this address width it can probe unaligned offsets, addresses just past the map and the top of the address range. All sixteen strobe patterns are applied to every offset, and each write is followed by a read. This exercises every lane edge against fields that span one, two and four lanes, including the shared packed offset. The reference model decides errors by counting strobed and unstrobed lanes per field, which is a different method from the edge mask used in the RTL.

// File: rtl/strobe_regfile.sv
module strobe_regfile #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CTRL  = 'h0,
  parameter logic [ADDR_W-1:0] OFF_PACK  = 'h4,
  parameter logic [ADDR_W-1:0] OFF_FULL  = 'h8,
  parameter logic [ADDR_W-1:0] OFF_SPLIT = 'hC,
  parameter logic [31:0] RST_CTRL  = 32'hA55A0F0F,
  parameter logic [7:0]  RST_PBYTE = 8'h56,
  parameter logic [15:0] RST_PHALF = 16'h1234,
  parameter logic [31:0] RST_FULL  = 32'hDEADBEEF,
  parameter logic [15:0] RST_SHI   = 16'hCAFE,
  parameter logic [7:0]  RST_SLO   = 8'h42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [3:0]        req_strb_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_error_o,
  output logic              rsp_ready_o
);

  function automatic logic [2:0] spans(input logic [3:0] m);
    return m[2:0] & m[3:1];
  endfunction

  localparam logic [3:0] M_CTOP  = 4'b1000;
  localparam logic [3:0] M_CMID  = 4'b0100;
  localparam logic [3:0] M_CLOW  = 4'b0011;
  localparam logic [3:0] M_PBYTE = 4'b0001;
  localparam logic [3:0] M_PHALF = 4'b0110;
  localparam logic [3:0] M_FULL  = 4'b1111;
  localparam logic [3:0] M_SHI   = 4'b1100;
  localparam logic [3:0] M_SLO   = 4'b0001;

  localparam logic [2:0] D_CTRL  = spans(M_CTOP) | spans(M_CMID) | spans(M_CLOW);
  localparam logic [2:0] D_PBYTE = spans(M_PBYTE);
  localparam logic [2:0] D_PHALF = spans(M_PHALF);
  localparam logic [2:0] D_FULL  = spans(M_FULL);
  localparam logic [2:0] D_SPLIT = spans(M_SHI) | spans(M_SLO);

  logic [7:0]  c_top_q, c_mid_q, p_byte_q, s_lo_q;
  logic [15:0] c_low_q, p_half_q, s_hi_q;
  logic [31:0] f_word_q;

  logic hit_ctrl, hit_pack, hit_full, hit_split, miss, bnd_err, wr_ok;
  logic [2:0] edges;

  assign hit_ctrl  = req_addr_i == OFF_CTRL;
  assign hit_pack  = req_addr_i == OFF_PACK;
  assign hit_full  = req_addr_i == OFF_FULL;
  assign hit_split = req_addr_i == OFF_SPLIT;
  assign miss      = ~(hit_ctrl | hit_pack | hit_full | hit_split);

  assign edges   = req_strb_i[2:0] ^ req_strb_i[3:1];
  assign bnd_err = (hit_ctrl  & (|(edges & D_CTRL)))
                 | (hit_pack  & (|(edges & D_PBYTE)))
                 | (hit_pack  & (|(edges & D_PHALF)))
                 | (hit_full  & (|(edges & D_FULL)))
                 | (hit_split & (|(edges & D_SPLIT)));

  assign wr_ok       = req_valid_i & req_write_i & ~miss & ~bnd_err;
  assign rsp_error_o = req_valid_i & (miss | (req_write_i & bnd_err));
  assign rsp_ready_o = 1'b1;

  logic we_ctop, we_cmid, we_clow, we_pbyte, we_phalf, we_full, we_shi, we_slo;
  assign we_ctop  = wr_ok & hit_ctrl  & (|(M_CTOP  & req_strb_i));
  assign we_cmid  = wr_ok & hit_ctrl  & (|(M_CMID  & req_strb_i));
  assign we_clow  = wr_ok & hit_ctrl  & (|(M_CLOW  & req_strb_i));
  assign we_pbyte = wr_ok & hit_pack  & (|(M_PBYTE & req_strb_i));
  assign we_phalf = wr_ok & hit_pack  & (|(M_PHALF & req_strb_i));
  assign we_full  = wr_ok & hit_full  & (|(M_FULL  & req_strb_i));
  assign we_shi   = wr_ok & hit_split & (|(M_SHI   & req_strb_i));
  assign we_slo   = wr_ok & hit_split & (|(M_SLO   & req_strb_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_top_q  <= RST_CTRL[31:24];
      c_mid_q  <= RST_CTRL[23:16];
      c_low_q  <= RST_CTRL[15:0];
      p_byte_q <= RST_PBYTE;
      p_half_q <= RST_PHALF;
      f_word_q <= RST_FULL;
      s_hi_q   <= RST_SHI;
      s_lo_q   <= RST_SLO;
    end else begin
      if (we_ctop)  c_top_q  <= req_wdata_i[31:24];
      if (we_cmid)  c_mid_q  <= req_wdata_i[23:16];
      if (we_clow)  c_low_q  <= req_wdata_i[15:0];
      if (we_pbyte) p_byte_q <= req_wdata_i[7:0];
      if (we_phalf) p_half_q <= req_wdata_i[23:8];
      if (we_full)  f_word_q <= req_wdata_i;
      if (we_shi)   s_hi_q   <= req_wdata_i[31:16];
      if (we_slo)   s_lo_q   <= req_wdata_i[7:0];
    end
  end

  always_comb begin
    rsp_rdata_o = '0;
    if (req_valid_i) begin
      if (hit_ctrl)  rsp_rdata_o = rsp_rdata_o | {c_top_q, c_mid_q, c_low_q};
      if (hit_pack)  rsp_rdata_o = rsp_rdata_o | {24'h0, p_byte_q};
      if (hit_pack)  rsp_rdata_o = rsp_rdata_o | {8'h0, p_half_q, 8'h0};
      if (hit_full)  rsp_rdata_o = rsp_rdata_o | f_word_q;
      if (hit_split) rsp_rdata_o = rsp_rdata_o | {s_hi_q, 8'h0, s_lo_q};
    end
  end

endmodule

// File: rtl/strobe_regfile_chk.sv
module strobe_regfile_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 'h0,
  parameter logic [ADDR_W-1:0] OFF_FULL = 'h8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [ADDR_W-1:0] addr,
  input logic              write,
  input logic [3:0]        strb,
  input logic              error,
  input logic [111:0]      state
);

  AST_FULL_PART_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    valid && write && addr == OFF_FULL && strb != 4'h0 && strb != 4'hF |-> error); // R4

  AST_ERR_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && write && error |=> $stable(state)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(state)); // R3

  AST_CTRL_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !write && addr == OFF_CTRL |-> !error); // R1

  AST_ZERO_STRB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && write && strb == 4'h0 |=> $stable(state)); // R9

endmodule

bind strobe_regfile strobe_regfile_chk #(
  .ADDR_W(ADDR_W), .OFF_CTRL(OFF_CTRL), .OFF_FULL(OFF_FULL)
) chk_i (
  .clk(clk_i), .rst_n(rst_ni), .valid(req_valid_i), .addr(req_addr_i),
  .write(req_write_i), .strb(req_strb_i), .error(rsp_error_o),
  .state({c_top_q, c_mid_q, c_low_q, p_byte_q, p_half_q, f_word_q, s_hi_q, s_lo_q})
);

// File: tb/strobe_regfile_tb_top.sv
module strobe_regfile_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  addr = '0;
  logic        write = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic [31:0] rdata;
  logic        err;
  logic        ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  strobe_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
    .req_write_i(write), .req_wdata_i(wdata), .req_strb_i(strb),
    .rsp_rdata_o(rdata), .rsp_error_o(err), .rsp_ready_o(ready)
  );

  int f_off [8] = '{0, 0, 0, 4, 4, 8, 12, 12};
  int f_lsb [8] = '{24, 16, 0, 0, 8, 0, 16, 0};
  int f_w   [8] = '{8, 8, 16, 8, 16, 32, 16, 8};
  logic [31:0] f_val [8];

  task automatic model_reset();
    f_val = '{32'hA5, 32'h5A, 32'h0F0F, 32'h56, 32'h1234, 32'hDEADBEEF, 32'hCAFE, 32'h42};
  endtask

  function automatic int lanes(int k, logic [3:0] s, bit want_on);
    int n = 0;
    for (int l = 0; l < 4; l++)
      if (f_lsb[k] <= l*8+7 && f_lsb[k]+f_w[k]-1 >= l*8)
        if (s[l] == want_on) n++;
    return n;
  endfunction

  function automatic logic [31:0] fmask(int w);
    return (w >= 32) ? 32'hFFFFFFFF : ((32'h1 << w) - 32'h1);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [7:0] a, logic w, logic [31:0] d, logic [3:0] s, string tag);
    logic [31:0] e_rd;
    bit hit, part, e_err;
    @(negedge clk);
    valid = v; addr = a; write = w; wdata = d; strb = s;
    #1;
    e_rd = '0; hit = 0; part = 0;
    for (int k = 0; k < 8; k++)
      if (f_off[k] == int'(a)) begin
        hit = 1;
        e_rd |= f_val[k] << f_lsb[k];
        if (lanes(k, s, 1) > 0 && lanes(k, s, 0) > 0) part = 1;
      end
    e_err = v && (!hit || (w && part));
    if (!v) e_rd = '0;
    check(tag, rdata, e_rd);
    check({tag, " error"}, {31'h0, err}, {31'h0, e_err});
    check("R7 ready", {31'h0, ready}, 32'h1);
    @(posedge clk);
    if (v && w && !e_err)
      for (int k = 0; k < 8; k++)
        if (f_off[k] == int'(a) && lanes(k, s, 1) > 0)
          f_val[k] = (d >> f_lsb[k]) & fmask(f_w[k]);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    step(1'b1, a, 1'b0, 32'h0, 4'h0, tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset values
    rd(8'h00, "R8 ctrl reset");
    rd(8'h04, "R8 pack reset");
    rd(8'h08, "R8 full reset");
    rd(8'h0C, "R8 split reset");
    step(1'b0, 8'h08, 1'b0, 32'h0, 4'h0, "R2 idle zero");

    // R1 misses: unaligned, past map, top of range
    step(1'b1, 8'h02, 1'b1, 32'hFFFFFFFF, 4'hF, "R1 miss write");
    step(1'b1, 8'h10, 1'b0, 32'h0, 4'h0, "R1 miss read");
    step(1'b1, 8'hFF, 1'b1, 32'h0, 4'hF, "R1 miss top");
    rd(8'h00, "R1 ctrl after miss");

    // R3 lane-selective writes on CTRL
    step(1'b1, 8'h00, 1'b1, 32'h11223344, 4'b1000, "R3 ctrl top only");
    rd(8'h00, "R3 ctrl readback");
    step(1'b1, 8'h00, 1'b1, 32'h55667788, 4'b0011, "R3 ctrl low only");
    rd(8'h00, "R3 ctrl readback2");
    step(1'b0, 8'h00, 1'b1, 32'h0, 4'hF, "R3 invalid write");
    rd(8'h00, "R3 unchanged");

    // R6 packed offset
    step(1'b1, 8'h04, 1'b1, 32'hAABBCCDD, 4'b0001, "R6 byte only");
    rd(8'h04, "R6 readback byte");
    step(1'b1, 8'h04, 1'b1, 32'h01020304, 4'b0110, "R6 half only");
    rd(8'h04, "R6 readback half");
    step(1'b1, 8'h04, 1'b1, 32'h99887766, 4'b0111, "R6 both");
    rd(8'h04, "R6 readback both");
    step(1'b1, 8'h04, 1'b1, 32'hFFFFFFFF, 4'b1000, "R6 unused lane");
    step(1'b1, 8'h04, 1'b1, 32'h0, 4'b0010, "R6 split half");
    step(1'b1, 8'h04, 1'b1, 32'h0, 4'b0100, "R6 split half2");
    rd(8'h04, "R6 after rejects");

    // R4 example: lane 2 alone against 31:16 field
    step(1'b1, 8'h0C, 1'b1, 32'h00FF0000, 4'b0100, "R4 split example");
    rd(8'h0C, "R5 split unchanged");

    // R9 empty strobe
    step(1'b1, 8'h08, 1'b1, 32'h0, 4'b0000, "R9 zero strobe");
    rd(8'h08, "R9 full unchanged");

    // R4 and R5: full strobe sweep on every offset
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 16; s++) begin
        step(1'b1, 8'(o*4), 1'b1, 32'h9E3779B9 * (o*16+s+1), 4'(s), "R4 sweep");
        rd(8'(o*4), "R5 sweep readback");
      end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule